// File: doc/BRIEF.md
# Multiplexed Bus Host Access Sequencer

This block is the host side of a multiplexed address/data bus that talks to a register-mapped peripheral controller. A single read or write request comes in on an internal port carrying the register address, the write data and a register class tag. The block latches it and drives the bus in a fixed order: an address phase with the latch enable high, a latch-hold phase, then a read or write strobe, then a short data-hold tail. It drives chip select low for the whole access. Each phase length comes from a minimum time in nanoseconds, divided by the system clock period and rounded up.

The peripheral needs extra recovery time after some accesses before it can take the next strobe. The block keeps the class and direction of the last completed access. From these and the pending request it works out the smallest number of strobe-high cycles allowed before the next strobe falls. These gaps are counted in arbitration periods, and an input doubles the arbitration period when it is set. A request waits, with ready low, until the sequencer is idle and enough strobe-high time has built up that the next strobe cannot come early. Read data is captured from the bus and presented alongside a one-cycle completion pulse.

Top module: `mbus_host_seq`

## Requirements
- R1: After reset, ale is 0, cs_n, wr_n and rd_n are 1, bus_oe and done are 0, and req_ready is 1.
- R2: An accepted request raises ale on the next cycle and holds it high for max(ceil(20/CLK_NS), ceil(10/CLK_NS)) cycles (2 by default). During that time cs_n is 0, bus_oe is 1 and bus_out carries the zero-extended address.
- R3: After ale falls, the address stays on bus_out with bus_oe at 1 for max(ceil(10/CLK_NS), ceil(15/CLK_NS), ceil(20/CLK_NS)) cycles (2 by default) before the strobe falls.
- R4: Exactly one of wr_n (req_wr=1) or rd_n (req_wr=0) goes low, for max(ceil(20/CLK_NS), ceil(30/CLK_NS)) cycles (3 by default). After the strobe rises, cs_n stays low for ceil(10/CLK_NS) cycles (1 by default). On a write, bus_out holds the write data with bus_oe at 1 for the whole strobe and the tail.
- R5: On a read, bus_oe is 0 during the strobe and the tail. rdata equals the bus_in value seen in the last strobe-low cycle and is valid while done is 1.
- R6: done is a one-cycle pulse in the last tail cycle of every access.
- R7: After a write to class 1 (address-pointer-low; class codes: 0 other, 1 address-pointer-low, 2 data), the next strobe falls only after at least 4 arbitration periods of strobe-high time.
- R8: A write to class 1 that follows any access (read or write) to class 2 waits at least 5 arbitration periods of strobe-high time from the previous strobe's rising edge.
- R9: Any other pair of accesses keeps the strobes high for at least ceil(20/CLK_NS) cycles. With a held request, the gap is exactly the larger of the recovery minimum and the natural turnaround of tail + 1 idle + address phase + hold phase (6 cycles by default).
- R10: The arbitration period is OPR_CYC system cycles when slow_arb is 0 and 2*OPR_CYC when slow_arb is 1.
- R11: A request is taken only on a cycle where req_ready is 1. req_ready is 0 while an access is in progress and while recovery is pending, and a held request is then left waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_arb | input | 1 | Doubles the arbitration period when 1 |
| req_valid | input | 1 | Request present |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_cls | input | 2 | Register class: 0 other, 1 address-pointer-low, 2 data |
| req_addr | input | AW | Register address |
| req_wdata | input | BW | Write data |
| req_ready | output | 1 | Request accepted on this edge when req_valid is 1 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | BW | Captured read data |
| ale | output | 1 | Address latch enable |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_out | output | BW | Multiplexed bus drive value |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | BW | Multiplexed bus sampled value |

## Verification
The hardest case to reach is a recovery gap decided by two accesses in a row: the previous access's class and direction together with the next request's class and direction, under each arbitration speed. Measuring it exactly also needs the second request to be waiting already, so that the gap shows the earliest legal acceptance and not the bench's own delay. The bench sweeps all 72 combinations of previous class, previous direction, next class, next direction and slow_arb. It issues the second request on the cycle right after the first is accepted and holds it, then counts strobe-high cycles at the pins. It checks that count against the arithmetic minimum for that pair.

// File: rtl/msq_pkg.sv
package msq_pkg;

   typedef enum logic [1:0] {
      CLS_OTHER  = 2'd0,
      CLS_PTR_LO = 2'd1,
      CLS_DATA   = 2'd2
   } reg_cls_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ALE  = 3'd1,
      PH_LAT  = 3'd2,
      PH_STB  = 3'd3,
      PH_TAIL = 3'd4
   } phase_e;

   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/msq_phase_fsm.sv
module msq_phase_fsm
   import msq_pkg::*;
#(
   parameter int unsigned A_CYC = 2,
   parameter int unsigned L_CYC = 2,
   parameter int unsigned S_CYC = 3,
   parameter int unsigned T_CYC = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_e phase,
   output logic   last
);

   localparam int unsigned MAXC = umax(umax(A_CYC, L_CYC), umax(S_CYC, T_CYC));
   localparam int unsigned CW   = $clog2(MAXC + 1);

   if (A_CYC < 1 || L_CYC < 1 || S_CYC < 1 || T_CYC < 1) begin : g_bad_len
      $error("msq_phase_fsm: every phase needs at least one cycle");
   end

   phase_e        ph_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len;
   phase_e        ph_next;

   always_comb begin
      case (ph_q)
         PH_ALE:  begin len = CW'(A_CYC); ph_next = PH_LAT;  end
         PH_LAT:  begin len = CW'(L_CYC); ph_next = PH_STB;  end
         PH_STB:  begin len = CW'(S_CYC); ph_next = PH_TAIL; end
         PH_TAIL: begin len = CW'(T_CYC); ph_next = PH_IDLE; end
         default: begin len = CW'(1);     ph_next = PH_IDLE; end
      endcase
   end

   assign last  = (ph_q != PH_IDLE) && (cnt_q == len - CW'(1));
   assign phase = ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (ph_q == PH_IDLE) begin
         if (start) begin
            ph_q  <= PH_ALE;
            cnt_q <= '0;
         end
      end else if (last) begin
         ph_q  <= ph_next;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // R4: the strobe phase is only ever entered from the latch-hold phase
   p_stb_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(ph_q) && ph_q == PH_STB) |-> $past(ph_q) == PH_LAT);

   // R11: a start is only presented while the sequencer is idle
   p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ph_q == PH_IDLE);

endmodule

// File: rtl/msq_recovery.sv
module msq_recovery
   import msq_pkg::*;
#(
   parameter int unsigned OPR_CYC  = 2,
   parameter int unsigned LEAD     = 4,
   parameter int unsigned HIGH_MIN = 2,
   parameter bit          SLOW_EN  = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_stb,
   input  logic     done,
   input  reg_cls_e done_cls,
   input  logic     done_wr,
   input  reg_cls_e req_cls,
   input  logic     req_wr,
   input  logic     slow_arb,
   output logic     gap_ok
);

   localparam int unsigned MAXG = 10 * OPR_CYC + HIGH_MIN;
   localparam int unsigned CW   = $clog2(MAXG + LEAD + 2) + 1;

   if (OPR_CYC < 1) begin : g_bad_opr
      $error("msq_recovery: OPR_CYC must be at least 1");
   end

   logic [CW-1:0] tarb;
   logic [CW-1:0] need;
   logic [CW-1:0] cnt_q;
   reg_cls_e      last_cls_q;
   logic          last_wr_q;
   logic [CW:0]   avail;

   if (SLOW_EN) begin : g_slow
      assign tarb = slow_arb ? CW'(2 * OPR_CYC) : CW'(OPR_CYC);
   end else begin : g_fixed
      assign tarb = CW'(OPR_CYC);
   end

   always_comb begin
      need = CW'(HIGH_MIN);
      if (last_cls_q == CLS_PTR_LO && last_wr_q && need < CW'(4) * tarb)
         need = CW'(4) * tarb;
      if (req_cls == CLS_PTR_LO && req_wr && last_cls_q == CLS_DATA && need < CW'(5) * tarb)
         need = CW'(5) * tarb;
   end

   assign avail  = {1'b0, cnt_q} + (CW + 1)'(LEAD + 1);
   assign gap_ok = avail >= {1'b0, need};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '1;
         last_cls_q <= CLS_OTHER;
         last_wr_q  <= 1'b0;
      end else begin
         if (in_stb)
            cnt_q <= '0;
         else if (cnt_q != '1)
            cnt_q <= cnt_q + CW'(1);
         if (done) begin
            last_cls_q <= done_cls;
            last_wr_q  <= done_wr;
         end
      end
   end

   // R7: clearance after a pointer-low write covers at least four operating periods
   p_ptr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_ok && last_cls_q == CLS_PTR_LO && last_wr_q) |->
      ({1'b0, cnt_q} + (CW + 1)'(LEAD + 1) >= (CW + 1)'(4 * OPR_CYC)));

   // R8: pointer-low write after a data access sees at least five operating periods
   p_data_ptr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_ok && req_cls == CLS_PTR_LO && req_wr && last_cls_q == CLS_DATA) |->
      ({1'b0, cnt_q} + (CW + 1)'(LEAD + 1) >= (CW + 1)'(5 * OPR_CYC)));

endmodule

// File: rtl/msq_bus_drive.sv
module msq_bus_drive
   import msq_pkg::*;
#(
   parameter int unsigned AW = 3,
   parameter int unsigned BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  phase_e        phase,
   input  logic          last,
   input  logic [AW-1:0] req_addr,
   input  logic [BW-1:0] req_wdata,
   input  logic          req_wr,
   input  reg_cls_e      req_cls,
   input  logic [BW-1:0] bus_in,
   output logic [BW-1:0] bus_out,
   output logic          bus_oe,
   output logic          acc_wr,
   output reg_cls_e      acc_cls,
   output logic [BW-1:0] rdata
);

   if (AW > BW) begin : g_bad_width
      $error("msq_bus_drive: address wider than bus");
   end

   logic [AW-1:0] addr_q;
   logic [BW-1:0] wdata_q;
   logic [BW-1:0] addr_ext;
   logic          addr_ph, data_ph;

   if (AW == BW) begin : g_full_addr
      assign addr_ext = addr_q;
   end else begin : g_ext_addr
      assign addr_ext = {{(BW - AW){1'b0}}, addr_q};
   end

   assign addr_ph = (phase == PH_ALE) || (phase == PH_LAT);
   assign data_ph = (phase == PH_STB) || (phase == PH_TAIL);
   assign bus_oe  = addr_ph || (data_ph && acc_wr);
   assign bus_out = addr_ph ? addr_ext : ((data_ph && acc_wr) ? wdata_q : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         acc_wr  <= 1'b0;
         acc_cls <= CLS_OTHER;
         rdata   <= '0;
      end else begin
         if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            acc_wr  <= req_wr;
            acc_cls <= req_cls;
         end
         if (phase == PH_STB && last && !acc_wr)
            rdata <= bus_in;
      end
   end

   // R5: no bus drive while a read strobe is active
   p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STB && !acc_wr) |-> !bus_oe);

endmodule

// File: rtl/mbus_host_seq.sv
module mbus_host_seq
   import msq_pkg::*;
#(
   parameter int unsigned AW           = 3,
   parameter int unsigned BW           = 8,
   parameter int unsigned CLK_NS       = 10,
   parameter int unsigned OPR_CYC      = 2,
   parameter bit          SLOW_EN      = 1'b1,
   parameter int unsigned ADDR_SU_NS   = 20,
   parameter int unsigned ADDR_HLD_NS  = 10,
   parameter int unsigned CS_SU_NS     = 10,
   parameter int unsigned CS_HLD_NS    = 10,
   parameter int unsigned ALE_HI_NS    = 20,
   parameter int unsigned ALE_LO_NS    = 20,
   parameter int unsigned ALE_STB_NS   = 15,
   parameter int unsigned WD_SU_NS     = 30,
   parameter int unsigned WD_HLD_NS    = 10,
   parameter int unsigned STB_LO_NS    = 20,
   parameter int unsigned STB_HI_NS    = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_arb,
   input  logic          req_valid,
   input  logic          req_wr,
   input  logic [1:0]    req_cls,
   input  logic [AW-1:0] req_addr,
   input  logic [BW-1:0] req_wdata,
   output logic          req_ready,
   output logic          done,
   output logic [BW-1:0] rdata,
   output logic          ale,
   output logic          cs_n,
   output logic          wr_n,
   output logic          rd_n,
   output logic [BW-1:0] bus_out,
   output logic          bus_oe,
   input  logic [BW-1:0] bus_in
);

   localparam int unsigned A_CYC = umax(umax(ns2cyc(ADDR_SU_NS, CLK_NS), ns2cyc(CS_SU_NS, CLK_NS)),
                                        ns2cyc(ALE_HI_NS, CLK_NS));
   localparam int unsigned L_CYC = umax(umax(ns2cyc(ADDR_HLD_NS, CLK_NS), ns2cyc(CS_HLD_NS, CLK_NS)),
                                        umax(ns2cyc(ALE_LO_NS, CLK_NS), ns2cyc(ALE_STB_NS, CLK_NS)));
   localparam int unsigned S_CYC = umax(umax(ns2cyc(STB_LO_NS, CLK_NS), ns2cyc(WD_SU_NS, CLK_NS)), 1);
   localparam int unsigned T_CYC = umax(ns2cyc(WD_HLD_NS, CLK_NS), 1);
   localparam int unsigned H_CYC = umax(ns2cyc(STB_HI_NS, CLK_NS), 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("mbus_host_seq: CLK_NS must be at least 1");
   end

   phase_e   phase;
   logic     last;
   logic     accept;
   logic     gap_ok;
   logic     acc_wr;
   reg_cls_e acc_cls;
   reg_cls_e req_cls_e;

   assign req_cls_e = reg_cls_e'(req_cls);
   assign req_ready = (phase == PH_IDLE) && gap_ok;
   assign accept    = req_valid && req_ready;
   assign done      = (phase == PH_TAIL) && last;
   assign ale       = (phase == PH_ALE);
   assign cs_n      = (phase == PH_IDLE);
   assign wr_n      = !((phase == PH_STB) && acc_wr);
   assign rd_n      = !((phase == PH_STB) && !acc_wr);

   msq_phase_fsm #(
      .A_CYC(A_CYC), .L_CYC(L_CYC), .S_CYC(S_CYC), .T_CYC(T_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(accept), .phase(phase), .last(last)
   );

   msq_recovery #(
      .OPR_CYC(OPR_CYC), .LEAD(A_CYC + L_CYC), .HIGH_MIN(H_CYC), .SLOW_EN(SLOW_EN)
   ) u_rec (
      .clk(clk), .rst_n(rst_n), .in_stb(phase == PH_STB), .done(done),
      .done_cls(acc_cls), .done_wr(acc_wr), .req_cls(req_cls_e), .req_wr(req_wr),
      .slow_arb(slow_arb), .gap_ok(gap_ok)
   );

   msq_bus_drive #(
      .AW(AW), .BW(BW)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .start(accept), .phase(phase), .last(last),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wr(req_wr), .req_cls(req_cls_e),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .acc_wr(acc_wr),
      .acc_cls(acc_cls), .rdata(rdata)
   );

   // R2: the latch enable and strobes only appear under chip select
   p_cs_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ale || !wr_n || !rd_n) |-> !cs_n);

   // R3: the address is still driven on the cycle the latch enable drops
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |-> (bus_oe && $stable(bus_out)));

   // R4: read and write strobes never overlap
   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!wr_n && !rd_n));

   // R6: completion is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: an access starts only after an edge on which a request met ready
   p_start_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |-> $past(req_valid && req_ready));

endmodule

// File: tb/mbus_host_seq_bench.sv
module mbus_host_seq_bench;

   localparam int AW = 3;
   localparam int BW = 8;
   localparam int CLK_NS = 10;
   localparam int OPR = 2;

   function automatic int cdiv(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_A   = 2;   // max(ceil 20, ceil 10, ceil 20) at 10 ns
   localparam int E_L   = 2;   // max(ceil 10, ceil 15, ceil 20)
   localparam int E_S   = 3;   // max(ceil 20, ceil 30)
   localparam int E_T   = 1;   // ceil 10
   localparam int E_HI  = 2;   // ceil 20
   localparam int E_NAT = E_T + 1 + E_A + E_L;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow_arb = 1'b0;
   logic req_valid = 1'b0;
   logic req_wr = 1'b0;
   logic [1:0] req_cls = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [BW-1:0] req_wdata = '0;
   logic req_ready, done, ale, cs_n, wr_n, rd_n, bus_oe;
   logic [BW-1:0] rdata, bus_out, bus_in;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   bit mon_on = 1'b0;

   logic          cur_wr = 1'b0;
   logic [AW-1:0] cur_addr = '0;
   logic [BW-1:0] cur_dat = '0;

   assign bus_in = rd_n ? '0 : cur_dat;

   always #5 clk = ~clk;

   mbus_host_seq u_mbus_host_seq (
      .clk(clk), .rst_n(rst_n), .slow_arb(slow_arb), .req_valid(req_valid),
      .req_wr(req_wr), .req_cls(req_cls), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .done(done), .rdata(rdata), .ale(ale), .cs_n(cs_n),
      .wr_n(wr_n), .rd_n(rd_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // pin monitor
   bit prev_stb = 0, prev_ale = 0, prev_done = 0, in_lat = 0, in_tail = 0;
   int ale_run = 0, lat_run = 0, stb_run = 0, tail_run = 0, hi_run = 0;
   int gap_meas = 0;
   int done_cnt = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         automatic bit stb = !wr_n || !rd_n;
         if (ale) begin
            ale_run++;
            check(!cs_n && bus_oe && bus_out == BW'(cur_addr), "R2 addr phase bus", int'(bus_out), int'(cur_addr));
         end else if (prev_ale) begin
            check(ale_run == E_A, "R2 ale width", ale_run, E_A);
            ale_run = 0; lat_run = 0; in_lat = 1;
         end
         if (in_lat && !ale && !stb) begin
            lat_run++;
            check(bus_oe && bus_out == BW'(cur_addr), "R3 addr hold", int'(bus_out), int'(cur_addr));
         end
         if (stb && !prev_stb) begin
            check(lat_run == E_L, "R3 hold length", lat_run, E_L);
            in_lat = 0; stb_run = 0; gap_meas = hi_run;
         end
         if (stb) begin
            stb_run++;
            hi_run = 0;
            check(!wr_n == cur_wr && !rd_n == !cur_wr, "R4 strobe select", int'(wr_n), int'(!cur_wr));
            if (cur_wr) check(bus_oe && bus_out == cur_dat, "R4 write data", int'(bus_out), int'(cur_dat));
            else        check(!bus_oe, "R5 read release", int'(bus_oe), 0);
         end else begin
            hi_run++;
         end
         if (!stb && prev_stb) begin
            check(stb_run == E_S, "R4 strobe width", stb_run, E_S);
            in_tail = 1; tail_run = 0;
         end
         if (in_tail && !stb) begin
            if (!cs_n) begin
               tail_run++;
               if (cur_wr) check(bus_oe && bus_out == cur_dat, "R4 data hold", int'(bus_out), int'(cur_dat));
            end else begin
               check(tail_run == E_T, "R4 tail length", tail_run, E_T);
               in_tail = 0;
            end
         end
         if (done) begin
            check(!prev_done, "R6 single pulse", 1, 0);
            check(in_tail && !cs_n, "R6 done in tail", int'(cs_n), 0);
            done_cnt++;
            if (!cur_wr) check(rdata == cur_dat, "R5 read data", int'(rdata), int'(cur_dat));
         end
         prev_stb = stb; prev_ale = ale; prev_done = done;
      end
   end

   task automatic issue(input int cls, input bit wr, input logic [AW-1:0] a,
                        input logic [BW-1:0] d, input bit chk_busy);
      @(negedge clk);
      if (chk_busy) check(!req_ready, "R11 ready low while busy", int'(req_ready), 0);
      req_valid = 1'b1; req_cls = 2'(cls); req_wr = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      cur_wr = wr; cur_addr = a; cur_dat = d;
   endtask

   function automatic int exp_gap(input int pc, input bit pw, input int nc, input bit nw, input bit slow);
      int tarb = OPR * (slow ? 2 : 1);
      int g = E_HI;
      if (pc == 1 && pw) g = mx(g, 4 * tarb);
      if (nc == 1 && nw && pc == 2) g = mx(g, 5 * tarb);
      return mx(g, E_NAT);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check(!ale && cs_n && wr_n && rd_n && !bus_oe && !done, "R1 idle pins in reset", int'(cs_n), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(!ale && cs_n && wr_n && rd_n && !bus_oe && !done, "R1 idle pins after reset", int'(ale), 0);
      check(req_ready, "R1 ready after reset", int'(req_ready), 1);
      mon_on = 1'b1;
      for (int s = 0; s < 2; s++) begin
         for (int pc = 0; pc < 3; pc++) begin
            for (int pw = 0; pw < 2; pw++) begin
               for (int nc = 0; nc < 3; nc++) begin
                  for (int nw = 0; nw < 2; nw++) begin
                     int eg, d0;
                     slow_arb = s[0];
                     repeat (40) @(negedge clk);
                     d0 = done_cnt;
                     issue(pc, pw[0], AW'(pc * 3 + pw), BW'(8'h5A ^ (pc * 17 + nc)), 1'b0);
                     issue(nc, nw[0], AW'(nc * 5 + nw + 1), BW'(8'hC3 + pc * 7 + nc * 3 + nw), 1'b1);
                     @(negedge clk);
                     req_valid = 1'b0;
                     while (done_cnt < d0 + 2 && done_cnt < d0 + 3) begin
                        @(negedge clk);
                        if (!cs_n && 0) break;
                     end
                     repeat (2) @(negedge clk);
                     eg = exp_gap(pc, pw[0], nc, nw[0], s[0]);
                     // R7 R8 R9 R10: exact strobe-high gap with a waiting request
                     check(gap_meas == eg, $sformatf("R7/R8/R9/R10 gap pc=%0d pw=%0d nc=%0d nw=%0d slow=%0d R10",
                           pc, pw, nc, nw, s), gap_meas, eg);
                     check(done_cnt == d0 + 2, "R6 one done per access", done_cnt - d0, 2);
                  end
               end
            end
         end
      end
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule